// File: doc/BRIEF.md
# MESI Snooping Coherence Controller for a Direct-Mapped Cache

This block keeps the coherence state of every line of one private, direct-mapped cache that sits on a shared snooping bus. It tracks a tag and a four-state MESI code per line. The processor side presents one request at a time, either a read or a write. A request that the present state already allows completes in the same cycle. Any other request is turned into a bus transaction: a read fill, a read-for-ownership, an invalidating upgrade, or a write-back flush of a dirty victim. Data storage, the memory model and bus arbitration lie outside this block. Only the state, tag and transaction decisions live here.

On the other side the controller watches the transactions that other caches place on the bus. It moves its own copy of the addressed line down the state order. It drives a shared response when a read finds a copy here, and a flush response when this cache holds the only dirty copy. When a local read fill is granted, the bus shared line sampled in that cycle decides whether the line lands Exclusive or Shared.

The line states are Invalid (code 0), Shared (1), Exclusive (2) and Modified (3). The request sequencer has three states:
- IDLE looks up the request.
- EVICT waits for the bus in order to write back a dirty victim.
- ACQ waits for the bus in order to fetch or upgrade the line.

The sequencer moves IDLE→EVICT on a miss over a Modified line and IDLE→ACQ on any other request that needs the bus. It moves EVICT→ACQ once the flush is granted, or at once if the victim is no longer dirty. It moves ACQ→IDLE when the fill or upgrade is granted.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid: for any address `cpu_hit` is 0 and `cpu_state` is 0, and `bus_req` is 0. An address is `{tag, index}`, with the index in the low `INDEX_W` bits.
- R2: A read whose tag matches a line in Shared (1), Exclusive (2) or Modified (3) raises `cpu_done` in the cycle it is presented. It raises no `bus_req` and leaves the state unchanged.
- R3: A read miss requests the bus with command read (`bus_cmd` 0) at `cpu_addr`. In the grant cycle `cpu_done` rises and the line is filled as Shared if `bus_shared` is 1, otherwise as Exclusive.
- R4: A write to an Exclusive line completes in the same cycle with no bus request, and the line becomes Modified. A write to a Modified line also completes at once and the line stays Modified.
- R5: A write to a Shared line requests the bus with command upgrade (`bus_cmd` 2) at `cpu_addr`. On grant it completes and the line becomes Modified.
- R6: A write miss requests the bus with command read-for-ownership (`bus_cmd` 1) at `cpu_addr`. On grant it completes and the line becomes Modified.
- R7: While `bus_req` is high and `bus_gnt` is low, `cpu_done` stays 0 and the state of the requested line does not change. The state update is made in the grant cycle.
- R8: A snooped read (`snp_cmd` 0) that hits a Shared or Exclusive line drives `snp_shared`=1 and `snp_flush`=0, and the line becomes Shared.
- R9: A snooped read that hits a Modified line drives both `snp_flush`=1 and `snp_shared`=1, and the line becomes Shared.
- R10: A snooped read-for-ownership (1) or upgrade (2) that hits a valid line makes it Invalid. It drives `snp_flush`=1 only if the line was Modified, and never drives `snp_shared`.
- R11: A snoop whose tag differs, that finds the line Invalid, that carries command flush (3), or that arrives while `bus_gnt` is high, drives neither response and changes no state.
- R12: A miss on an index whose line is Modified with another tag first requests a flush (`bus_cmd` 3) at `{old tag, index}`. On that grant the old line becomes Invalid, and then the fill of R3/R6 follows. If a snoop has already cleaned the victim before the grant, the flush is dropped and the fill is requested directly.
- R13: In IDLE, a snoop to the same index as the pending request takes the cycle: the snoop update is applied and `cpu_done` stays 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Request address `{tag, index}` |
| cpu_done | output | 1 | Request completes this cycle |
| cpu_hit | output | 1 | Tag of `cpu_addr` matches a valid line |
| cpu_state | output | 2 | State of the line for `cpu_addr` (0 if no match) |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant for this cache |
| bus_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 upgrade, 3 flush |
| bus_addr | output | ADDR_W | Bus transaction address |
| bus_shared | input | 1 | Shared line, sampled on a granted read fill |
| snp_valid | input | 1 | A transaction from another cache is on the bus |
| snp_cmd | input | 2 | Snooped command, same coding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped address |
| snp_shared | output | 1 | This cache holds the block read by the snoop |
| snp_flush | output | 1 | This cache supplies its dirty copy |

## Verification
The bench builds the controller with a 4-bit address and a single index bit. That gives two lines with eight tags each, small enough to reach every line state on both indices and pair it with every local operation and every snooped command, both hitting and missing. It also makes victim conflicts easy to provoke, so the write-back path, the dropped write-back and the same-index snoop stall can each be staged cycle by cycle.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } line_st_t;

    typedef enum logic [1:0] {
        CMD_RD    = 2'd0,
        CMD_RDX   = 2'd1,
        CMD_UPGR  = 2'd2,
        CMD_FLUSH = 2'd3
    } bus_cmd_t;

    typedef enum logic [1:0] {
        CT_IDLE  = 2'd0,
        CT_EVICT = 2'd1,
        CT_ACQ   = 2'd2
    } ctl_st_t;

endpackage

// File: rtl/mesi_tag_array.sv
module mesi_tag_array
    import mesi_pkg::*;
#(
    parameter int TAG_W   = 3,
    parameter int INDEX_W = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INDEX_W-1:0] rd_idx_a,
    output logic [TAG_W-1:0]   rd_tag_a,
    output line_st_t           rd_st_a,
    input  logic [INDEX_W-1:0] rd_idx_b,
    output logic [TAG_W-1:0]   rd_tag_b,
    output line_st_t           rd_st_b,
    input  logic               lw_en,
    input  logic [INDEX_W-1:0] lw_idx,
    input  logic [TAG_W-1:0]   lw_tag,
    input  line_st_t           lw_st,
    input  logic               sw_en,
    input  logic [INDEX_W-1:0] sw_idx,
    input  line_st_t           sw_st
);

    localparam int LINES = 1 << INDEX_W;

    logic [TAG_W-1:0] tag_q [LINES];
    line_st_t         st_q  [LINES];

    // Local writes and snoop writes never target the same index in one
    // cycle; the local port still takes precedence as a safe default.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                tag_q[i] <= '0;
                st_q[i]  <= ST_I;
            end
        end else begin
            for (int i = 0; i < LINES; i++) begin
                if (lw_en && lw_idx == INDEX_W'(i)) begin
                    tag_q[i] <= lw_tag;
                    st_q[i]  <= lw_st;
                end else if (sw_en && sw_idx == INDEX_W'(i)) begin
                    st_q[i]  <= sw_st;
                end
            end
        end
    end

    assign rd_tag_a = tag_q[rd_idx_a];
    assign rd_st_a  = st_q[rd_idx_a];
    assign rd_tag_b = tag_q[rd_idx_b];
    assign rd_st_b  = st_q[rd_idx_b];

endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
    import mesi_pkg::*;
(
    input  logic     active,
    input  logic     hit,
    input  line_st_t cur,
    input  bus_cmd_t cmd,
    output logic     upd,
    output line_st_t nxt,
    output logic     shared,
    output logic     flush
);

    always_comb begin
        nxt    = cur;
        shared = 1'b0;
        flush  = 1'b0;
        if (active && hit) begin
            unique case (cmd)
                CMD_RD: begin
                    shared = 1'b1;
                    flush  = (cur == ST_M);
                    nxt    = ST_S;
                end
                CMD_RDX, CMD_UPGR: begin
                    flush  = (cur == ST_M);
                    nxt    = ST_I;
                end
                CMD_FLUSH: begin
                    nxt    = cur;
                end
                default: nxt = cur;
            endcase
        end
        upd = (nxt != cur);
    end

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int INDEX_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_done,
    output logic              cpu_hit,
    output logic [1:0]        cpu_state,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_shared,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_shared,
    output logic              snp_flush
);

    localparam int TAG_W = ADDR_W - INDEX_W;

    ctl_st_t ctl_q, ctl_d;

    logic [INDEX_W-1:0] req_idx, sn_idx;
    logic [TAG_W-1:0]   req_tag, sn_tag;
    logic [TAG_W-1:0]   lk_tag, sl_tag;
    line_st_t           lk_st, sl_st;

    logic               req_hit, sn_hit, snp_act, snp_collide;
    logic               lw_en;
    logic [TAG_W-1:0]   lw_tag;
    line_st_t           lw_st;
    logic               sw_en;
    line_st_t           sw_st;
    bus_cmd_t           cmd_w;

    assign req_idx = cpu_addr[INDEX_W-1:0];
    assign req_tag = cpu_addr[ADDR_W-1:INDEX_W];
    assign sn_idx  = snp_addr[INDEX_W-1:0];
    assign sn_tag  = snp_addr[ADDR_W-1:INDEX_W];

    mesi_tag_array #(
        .TAG_W   (TAG_W),
        .INDEX_W (INDEX_W)
    ) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx_a (req_idx),
        .rd_tag_a (lk_tag),
        .rd_st_a  (lk_st),
        .rd_idx_b (sn_idx),
        .rd_tag_b (sl_tag),
        .rd_st_b  (sl_st),
        .lw_en    (lw_en),
        .lw_idx   (req_idx),
        .lw_tag   (lw_tag),
        .lw_st    (lw_st),
        .sw_en    (sw_en),
        .sw_idx   (sn_idx),
        .sw_st    (sw_st)
    );

    // Snooped traffic is only ours to answer when this cache is not the
    // current bus owner.
    assign snp_act     = snp_valid && !bus_gnt;
    assign sn_hit      = (sl_st != ST_I) && (sl_tag == sn_tag);
    assign snp_collide = snp_act && (sn_idx == req_idx);

    mesi_snoop_resp u_snoop (
        .active (snp_act),
        .hit    (sn_hit),
        .cur    (sl_st),
        .cmd    (bus_cmd_t'(snp_cmd)),
        .upd    (sw_en),
        .nxt    (sw_st),
        .shared (snp_shared),
        .flush  (snp_flush)
    );

    assign req_hit   = (lk_st != ST_I) && (lk_tag == req_tag);
    assign cpu_hit   = req_hit;
    assign cpu_state = req_hit ? lk_st : ST_I;
    assign bus_cmd   = cmd_w;

    // State register of the request sequencer.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CT_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // Next state, bus outputs and local line updates.
    always_comb begin
        ctl_d    = ctl_q;
        cpu_done = 1'b0;
        bus_req  = 1'b0;
        cmd_w    = CMD_RD;
        bus_addr = cpu_addr;
        lw_en    = 1'b0;
        lw_tag   = req_tag;
        lw_st    = lk_st;
        unique case (ctl_q)
            CT_IDLE: begin
                if (cpu_req && !snp_collide) begin
                    if (req_hit && (!cpu_wr || lk_st == ST_M || lk_st == ST_E)) begin
                        cpu_done = 1'b1;
                        if (cpu_wr && lk_st == ST_E) begin
                            lw_en = 1'b1;
                            lw_st = ST_M;
                        end
                    end else if (!req_hit && lk_st == ST_M) begin
                        ctl_d = CT_EVICT;
                    end else begin
                        ctl_d = CT_ACQ;
                    end
                end
            end
            CT_EVICT: begin
                if (lk_st == ST_M && lk_tag != req_tag) begin
                    bus_req  = 1'b1;
                    cmd_w    = CMD_FLUSH;
                    bus_addr = {lk_tag, req_idx};
                    if (bus_gnt) begin
                        lw_en  = 1'b1;
                        lw_tag = lk_tag;
                        lw_st  = ST_I;
                        ctl_d  = CT_ACQ;
                    end
                end else begin
                    ctl_d = CT_ACQ;
                end
            end
            CT_ACQ: begin
                bus_req = 1'b1;
                if (!cpu_wr) begin
                    cmd_w = CMD_RD;
                end else if (req_hit && lk_st == ST_S) begin
                    cmd_w = CMD_UPGR;
                end else begin
                    cmd_w = CMD_RDX;
                end
                if (bus_gnt) begin
                    lw_en    = 1'b1;
                    lw_tag   = req_tag;
                    lw_st    = cpu_wr ? ST_M : (bus_shared ? ST_S : ST_E);
                    cpu_done = 1'b1;
                    ctl_d    = CT_IDLE;
                end
            end
            default: ctl_d = CT_IDLE;
        endcase
    end

endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk #(
    parameter int ADDR_W  = 8,
    parameter int INDEX_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_wr,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_done,
    input logic              cpu_hit,
    input logic [1:0]        cpu_state,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic [1:0]        bus_cmd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_shared,
    input logic              snp_valid,
    input logic [1:0]        snp_cmd,
    input logic [ADDR_W-1:0] snp_addr,
    input logic              snp_shared,
    input logic              snp_flush
);

    p_wait_no_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |-> !cpu_done);

    p_done_has_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> cpu_req);

    p_quiet_done_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_done && !bus_req) |-> cpu_hit);

    p_rd_for_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_cmd == 2'd0) |-> !cpu_wr);

    p_upgr_on_shared_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_cmd == 2'd2) |-> (cpu_wr && cpu_state == 2'd1));

    p_shared_on_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        snp_shared |-> (snp_valid && snp_cmd == 2'd0 && !bus_gnt));

    p_flush_on_snoop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        snp_flush |-> (snp_valid && snp_cmd != 2'd3 && !bus_gnt));

    p_victim_index_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_cmd == 2'd3) |->
            (bus_addr[INDEX_W-1:0] == cpu_addr[INDEX_W-1:0] && bus_addr != cpu_addr));

endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk #(
    .ADDR_W  (ADDR_W),
    .INDEX_W (INDEX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_req    (cpu_req),
    .cpu_wr     (cpu_wr),
    .cpu_addr   (cpu_addr),
    .cpu_done   (cpu_done),
    .cpu_hit    (cpu_hit),
    .cpu_state  (cpu_state),
    .bus_req    (bus_req),
    .bus_gnt    (bus_gnt),
    .bus_cmd    (bus_cmd),
    .bus_addr   (bus_addr),
    .bus_shared (bus_shared),
    .snp_valid  (snp_valid),
    .snp_cmd    (snp_cmd),
    .snp_addr   (snp_addr),
    .snp_shared (snp_shared),
    .snp_flush  (snp_flush)
);

// File: tb/mesi_line_ctrl_test.sv
module mesi_line_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam int IW = 1;

    logic          clk;
    logic          rst_n;
    logic          cpu_req, cpu_wr;
    logic [AW-1:0] cpu_addr;
    logic          cpu_done, cpu_hit;
    logic [1:0]    cpu_state;
    logic          bus_req, bus_gnt, bus_shared;
    logic [1:0]    bus_cmd;
    logic [AW-1:0] bus_addr;
    logic          snp_valid;
    logic [1:0]    snp_cmd;
    logic [AW-1:0] snp_addr;
    logic          snp_shared, snp_flush;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 0;

    int log_cmd [4];
    int log_addr[4];
    int nlog;
    int cycs;
    int o_sh, o_fl, o_hit, o_st;

    mesi_line_ctrl #(.ADDR_W(AW), .INDEX_W(IW)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_done(cpu_done), .cpu_hit(cpu_hit),
        .cpu_state(cpu_state), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_shared(bus_shared),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_shared(snp_shared), .snp_flush(snp_flush)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD/2) clk = ~clk;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic reset_dut();
        @(negedge clk);
        rst_n = 1'b0;
        cpu_req = 0; cpu_wr = 0; cpu_addr = '0;
        bus_gnt = 0; bus_shared = 0;
        snp_valid = 0; snp_cmd = 0; snp_addr = '0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic peek(input int addr);
        cpu_addr = AW'(addr);
        #1;
        o_hit = int'(cpu_hit);
        o_st  = int'(cpu_state);
    endtask

    // Runs one processor request to completion, granting the bus after
    // gdly waiting cycles of each bus request.
    task automatic do_req(input bit wr, input int addr, input int gdly, input bit sh);
        int wcnt = 0;
        int pre;
        bit done = 0;
        nlog = 0;
        cycs = 0;
        @(negedge clk);
        cpu_req = 1; cpu_wr = wr; cpu_addr = AW'(addr);
        #1;
        pre = int'(cpu_state);
        for (int k = 0; k < 20 && !done; k++) begin
            if (bus_req) begin
                if (wcnt >= gdly) begin
                    bus_gnt = 1; bus_shared = sh;
                    if (nlog < 4) begin
                        log_cmd[nlog]  = int'(bus_cmd);
                        log_addr[nlog] = int'(bus_addr);
                    end
                    nlog++;
                    wcnt = 0;
                end else begin
                    wcnt++;
                    chk(cpu_done == 0, "R7 done while waiting", int'(cpu_done), 0);
                    chk(int'(cpu_state) == pre, "R7 state while waiting", int'(cpu_state), pre);
                end
            end
            #1;
            done = cpu_done;
            cycs++;
            @(posedge clk);
            @(negedge clk);
            bus_gnt = 0; bus_shared = 0;
            if (!done) #1;
        end
        cpu_req = 0;
    endtask

    task automatic snoop(input int cmd, input int addr, input bit gnt);
        @(negedge clk);
        snp_valid = 1; snp_cmd = 2'(cmd); snp_addr = AW'(addr); bus_gnt = gnt;
        #1;
        o_sh = int'(snp_shared);
        o_fl = int'(snp_flush);
        @(posedge clk);
        @(negedge clk);
        snp_valid = 0; bus_gnt = 0;
    endtask

    task automatic setup(input int st, input int addr);
        reset_dut();
        case (st)
            1: do_req(0, addr, 0, 1);
            2: do_req(0, addr, 0, 0);
            3: do_req(1, addr, 0, 0);
            default: ;
        endcase
        peek(addr);
        chk(o_st == st, (st == 3) ? "R6 setup state" : "R3 setup state", o_st, st);
    endtask

    function automatic int exp_snp_st(input int st, input int cmd);
        if (st == 0) return 0;
        case (cmd)
            0: return 1;
            1, 2: return 0;
            default: return st;
        endcase
    endfunction

    function automatic string snp_tag(input int st, input int cmd);
        if (st == 0 || cmd == 3) return "R11";
        if (cmd == 0) return (st == 3) ? "R9" : "R8";
        return "R10";
    endfunction

    initial begin
        rst_n = 1'b0;
        cpu_req = 0; cpu_wr = 0; cpu_addr = '0;
        bus_gnt = 0; bus_shared = 0;
        snp_valid = 0; snp_cmd = 0; snp_addr = '0;

        // R1: reset state
        reset_dut();
        for (int a = 0; a < 16; a++) begin
            peek(a);
            chk(o_hit == 0 && o_st == 0, "R1 line invalid after reset", o_st, 0);
        end
        chk(bus_req == 0, "R1 no bus request after reset", int'(bus_req), 0);

        // Sweep: every index, every start state, every operation.
        for (int idx = 0; idx < 2; idx++) begin
            for (int st = 0; st < 4; st++) begin
                for (int op = 0; op < 10; op++) begin
                    int A = 3 * 2 + idx;
                    int B = 7 * 2 + idx;
                    setup(st, A);
                    if (op == 0) begin
                        do_req(0, A, 2, 1);
                        peek(A);
                        if (st != 0) begin
                            chk(nlog == 0 && cycs == 1, "R2 read hit no bus", nlog, 0);
                            chk(o_st == st, "R2 read hit state", o_st, st);
                        end else begin
                            chk(nlog == 1 && log_cmd[0] == 0 && log_addr[0] == A,
                                "R3 read miss command", log_cmd[0], 0);
                            chk(o_st == 1, "R3 fill shared", o_st, 1);
                        end
                    end else if (op == 1) begin
                        do_req(1, A, 2, 0);
                        peek(A);
                        if (st >= 2) begin
                            chk(nlog == 0 && cycs == 1, "R4 silent write", nlog, 0);
                            chk(o_st == 3, "R4 write to modified", o_st, 3);
                        end else if (st == 1) begin
                            chk(nlog == 1 && log_cmd[0] == 2 && log_addr[0] == A,
                                "R5 upgrade command", log_cmd[0], 2);
                            chk(o_st == 3, "R5 upgrade state", o_st, 3);
                        end else begin
                            chk(nlog == 1 && log_cmd[0] == 1 && log_addr[0] == A,
                                "R6 read-for-ownership command", log_cmd[0], 1);
                            chk(o_st == 3, "R6 write miss state", o_st, 3);
                        end
                    end else if (op < 6) begin
                        int c = op - 2;
                        int es = exp_snp_st(st, c);
                        snoop(c, A, 0);
                        chk(o_sh == int'(st != 0 && c == 0), {snp_tag(st, c), " shared"},
                            o_sh, int'(st != 0 && c == 0));
                        chk(o_fl == int'(st == 3 && c != 3), {snp_tag(st, c), " flush"},
                            o_fl, int'(st == 3 && c != 3));
                        peek(A);
                        chk(o_st == es, {snp_tag(st, c), " state"}, o_st, es);
                    end else begin
                        int c = op - 6;
                        snoop(c, B, 0);
                        chk(o_sh == 0 && o_fl == 0, "R11 miss snoop response", o_sh + o_fl, 0);
                        peek(A);
                        chk(o_st == st, "R11 miss snoop state", o_st, st);
                    end
                end
            end
        end

        // R11: snoop ignored while this cache owns the bus
        setup(2, 6);
        snoop(1, 6, 1);
        chk(o_sh == 0 && o_fl == 0, "R11 snoop during grant response", o_sh + o_fl, 0);
        peek(6);
        chk(o_st == 2, "R11 snoop during grant state", o_st, 2);

        // R12: dirty victim written back before the fill, read and write
        for (int wr = 0; wr < 2; wr++) begin
            setup(3, 6);
            do_req(wr[0], 14, 1, 0);
            chk(nlog == 2, "R12 two transactions", nlog, 2);
            chk(log_cmd[0] == 3 && log_addr[0] == 6, "R12 flush of victim", log_addr[0], 6);
            chk(log_cmd[1] == (wr ? 1 : 0) && log_addr[1] == 14, "R12 fill after flush",
                log_cmd[1], wr ? 1 : 0);
            peek(14);
            chk(o_st == (wr ? 3 : 2), "R12 new line state", o_st, wr ? 3 : 2);
            peek(6);
            chk(o_hit == 0, "R12 old line gone", o_hit, 0);
        end

        // R12: victim cleaned by a snoop while waiting, flush dropped
        setup(3, 6);
        @(negedge clk);
        cpu_req = 1; cpu_wr = 0; cpu_addr = 4'd14;
        @(negedge clk);
        #1;
        chk(bus_req == 1 && bus_cmd == 2'd3, "R12 flush requested", int'(bus_cmd), 3);
        snp_valid = 1; snp_cmd = 2'd0; snp_addr = 4'd6;
        #1;
        chk(snp_flush == 1, "R9 flush while evicting", int'(snp_flush), 1);
        @(negedge clk);
        snp_valid = 0;
        #1;
        chk(bus_req == 0, "R12 flush dropped", int'(bus_req), 0);
        @(negedge clk);
        #1;
        chk(bus_req == 1 && bus_cmd == 2'd0 && bus_addr == 4'd14, "R12 direct fill",
            int'(bus_cmd), 0);
        bus_gnt = 1;
        #1;
        chk(cpu_done == 1, "R3 done on grant", int'(cpu_done), 1);
        @(negedge clk);
        bus_gnt = 0; cpu_req = 0;
        peek(14);
        chk(o_st == 2, "R3 fill exclusive", o_st, 2);

        // R13: same-index snoop stalls the local request for one cycle
        setup(2, 6);
        @(negedge clk);
        cpu_req = 1; cpu_wr = 1; cpu_addr = 4'd6;
        snp_valid = 1; snp_cmd = 2'd1; snp_addr = 4'd6;
        #1;
        chk(cpu_done == 0, "R13 local stalled", int'(cpu_done), 0);
        @(negedge clk);
        snp_valid = 0; cpu_req = 0;
        peek(6);
        chk(o_st == 0, "R13 snoop applied", o_st, 0);

        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!ended) begin
            ended = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule